// File: doc/BRIEF.md
# Operating Mode Strap Controller

This block fixes the chip's operating mode from three strap pins and then guards later changes to it. While reset is held, the strap value is copied into a mode register on every clock edge. The value present at the last edge before reset is released becomes the starting mode.

From the mode the block derives a set of class flags: single chip, expanded, wide bus, special, emulation and peripheral. It also derives a function select for each of two 8-bit ports. A port can be plain I/O, the high address byte, a multiplexed address/data byte, or handed to an external host.

Software may request a new mode through a write strobe. Each mode carries one of three write policies:
- **Anytime:** any write is accepted.
- **Once:** one write is accepted, and only towards a normal expanded mode.
- **Never:** every write is refused.

A refused write leaves the mode as it was and raises a flag for one cycle.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads `strap_i` into the mode register. After release, `mode_o` equals the strap value present at the last edge with reset low, and `wr_ignored_o` is 0.
- R2: Mode codes are decoded as follows: 000 special single chip, 001 emulation narrow, 010 special test wide, 011 emulation wide, 100 normal single chip, 101 normal narrow, 110 peripheral, 111 normal wide. Exactly one of `single_o`, `expanded_o` and `periph_o` is high. `wide_o` is high for 010, 011 and 111. `special_o` is high for 000 and 010. `emul_o` is high for 001 and 011.
- R3: In single-chip modes (000, 100), both `port_a_fn_o` and `port_b_fn_o` are 0, meaning general I/O.
- R4: In narrow modes (001, 101), `port_a_fn_o` is 1 (high address byte only) and `port_b_fn_o` is 2 (low address multiplexed with data).
- R5: In wide modes (010, 011, 111), both ports are 2 (address multiplexed with data). In peripheral mode (110), both ports are 3 (external host).
- R6: In modes 000 and 010, a write of any target is accepted. `mode_o` shows the target from the next edge.
- R7: In mode 100, the first write that targets 101 or 111 is accepted.
- R8: In mode 100, a write that targets any other code is refused. A refused write does not use up the one allowed write, so a later write to 101 or 111 is still accepted.
- R9: In modes 001, 011, 101, 110 and 111, every write is refused.
- R10: A refused write leaves `mode_o` unchanged. `wr_ignored_o` is 1 for exactly the cycle after the refused write and 0 after an accepted write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while low |
| strap_i | input | 3 | Mode strap pins |
| wr_en_i | input | 1 | Mode write strobe |
| wr_mode_i | input | 3 | Requested mode code |
| mode_o | output | 3 | Current mode code |
| single_o | output | 1 | Single-chip mode |
| expanded_o | output | 1 | Expanded-bus mode |
| wide_o | output | 1 | 16-bit wide bus |
| special_o | output | 1 | Special mode |
| emul_o | output | 1 | Emulation mode |
| periph_o | output | 1 | Peripheral mode |
| port_a_fn_o | output | 2 | Port A function select |
| port_b_fn_o | output | 2 | Port B function select |
| wr_ignored_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The block has no tunable parameters, so the bench uses its only configuration. It walks every strap value through every pair of consecutive write targets, which is 512 sequences. This covers every mode reached after reset and every mode reached by one accepted write. It therefore exercises each policy against every target, a refused write followed by the one allowed write from normal single chip, and the frozen modes that can only be entered from a special mode. After each step the bench checks the decoded flags and the port selects against the mode bits, and it checks that the refusal pulse has dropped on the following idle cycle.

// File: rtl/opm_pkg.sv
package opm_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_SPC_SINGLE = 3'd0,
        M_EMU_NARROW = 3'd1,
        M_SPC_TEST   = 3'd2,
        M_EMU_WIDE   = 3'd3,
        M_NRM_SINGLE = 3'd4,
        M_NRM_NARROW = 3'd5,
        M_PERIPH     = 3'd6,
        M_NRM_WIDE   = 3'd7
    } opm_mode_e;

    typedef enum logic [1:0] {
        POL_ANY   = 2'd0,
        POL_ONCE  = 2'd1,
        POL_NEVER = 2'd2
    } opm_pol_e;

    typedef enum logic [1:0] {
        PF_GPIO = 2'd0,
        PF_ADDR = 2'd1,
        PF_MUX  = 2'd2,
        PF_EXT  = 2'd3
    } opm_pfn_e;

    typedef struct packed {
        logic     single;
        logic     expanded;
        logic     wide;
        logic     special;
        logic     emul;
        logic     periph;
        opm_pfn_e port_a;
        opm_pfn_e port_b;
    } opm_flags_t;

    typedef struct packed {
        opm_mode_e mode;
        logic      once_used;
        logic      ignored;
    } opm_state_t;
endpackage

// File: rtl/opm_decode.sv
module opm_decode
    import opm_pkg::*;
(
    input  opm_mode_e  mode_i,
    output opm_flags_t flags_o,
    output opm_pol_e   policy_o
);
    always_comb begin
        flags_o = '0;
        flags_o.port_a = PF_GPIO;
        flags_o.port_b = PF_GPIO;
        policy_o = POL_NEVER;
        unique case (mode_i)
            M_SPC_SINGLE: begin
                flags_o.single  = 1'b1;
                flags_o.special = 1'b1;
                policy_o        = POL_ANY;
            end
            M_SPC_TEST: begin
                flags_o.expanded = 1'b1;
                flags_o.wide     = 1'b1;
                flags_o.special  = 1'b1;
                flags_o.port_a   = PF_MUX;
                flags_o.port_b   = PF_MUX;
                policy_o         = POL_ANY;
            end
            M_NRM_SINGLE: begin
                flags_o.single = 1'b1;
                policy_o       = POL_ONCE;
            end
            M_EMU_NARROW, M_NRM_NARROW: begin
                flags_o.expanded = 1'b1;
                flags_o.emul     = (mode_i == M_EMU_NARROW);
                flags_o.port_a   = PF_ADDR;
                flags_o.port_b   = PF_MUX;
            end
            M_EMU_WIDE, M_NRM_WIDE: begin
                flags_o.expanded = 1'b1;
                flags_o.wide     = 1'b1;
                flags_o.emul     = (mode_i == M_EMU_WIDE);
                flags_o.port_a   = PF_MUX;
                flags_o.port_b   = PF_MUX;
            end
            M_PERIPH: begin
                flags_o.periph = 1'b1;
                flags_o.port_a = PF_EXT;
                flags_o.port_b = PF_EXT;
            end
            default: ;
        endcase
    end

    always_comb begin
        a_class_r2: assert ($onehot({flags_o.single, flags_o.expanded, flags_o.periph}));
    end
endmodule

// File: rtl/opm_policy.sv
module opm_policy
    import opm_pkg::*;
(
    input  opm_pol_e  policy_i,
    input  logic      once_used_i,
    input  opm_mode_e target_i,
    output logic      accept_o
);
    logic target_ok;

    assign target_ok = (target_i == M_NRM_NARROW) || (target_i == M_NRM_WIDE);

    always_comb begin
        unique case (policy_i)
            POL_ANY:  accept_o = 1'b1;
            POL_ONCE: accept_o = !once_used_i && target_ok;
            default:  accept_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
    import opm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_mode_i,
    output logic [2:0] mode_o,
    output logic       single_o,
    output logic       expanded_o,
    output logic       wide_o,
    output logic       special_o,
    output logic       emul_o,
    output logic       periph_o,
    output logic [1:0] port_a_fn_o,
    output logic [1:0] port_b_fn_o,
    output logic       wr_ignored_o
);
    opm_state_t st_d, st_q;
    opm_flags_t flags;
    opm_pol_e   policy;
    logic       accept;

    opm_decode u_decode (
        .mode_i  (st_q.mode),
        .flags_o (flags),
        .policy_o(policy)
    );

    opm_policy u_policy (
        .policy_i   (policy),
        .once_used_i(st_q.once_used),
        .target_i   (opm_mode_e'(wr_mode_i)),
        .accept_o   (accept)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ignored = 1'b0;
        if (!rst_n) begin
            st_d.mode      = opm_mode_e'(strap_i);
            st_d.once_used = 1'b0;
        end else if (wr_en_i) begin
            if (accept) begin
                st_d.mode = opm_mode_e'(wr_mode_i);
                if (policy == POL_ONCE) st_d.once_used = 1'b1;
            end else begin
                st_d.ignored = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o       = st_q.mode;
    assign single_o     = flags.single;
    assign expanded_o   = flags.expanded;
    assign wide_o       = flags.wide;
    assign special_o    = flags.special;
    assign emul_o       = flags.emul;
    assign periph_o     = flags.periph;
    assign port_a_fn_o  = flags.port_a;
    assign port_b_fn_o  = flags.port_b;
    assign wr_ignored_o = st_q.ignored;

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o[2] && mode_o[0]) || (mode_o[2] && (mode_o != 3'd4)) |=> $stable(mode_o));

    p_ignored_keeps_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ignored_o |-> $past(wr_en_i) && $stable(mode_o));

    p_once_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |=> (mode_o == 3'd4) || (mode_o == 3'd5) || (mode_o == 3'd7));

    p_idle_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> !wr_ignored_o);

    p_special_accepts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && special_o) |=> !wr_ignored_o && (mode_o == $past(wr_mode_i)));
endmodule

// File: tb/test_opmode_ctrl.sv
module test_opmode_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap_i = '0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_mode_i = '0;
    logic [2:0] mode_o;
    logic       single_o, expanded_o, wide_o, special_o, emul_o, periph_o;
    logic [1:0] port_a_fn_o, port_b_fn_o;
    logic       wr_ignored_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    logic [2:0] m_mode;
    bit         m_once;

    always #(CLK_PERIOD/2) clk = ~clk;

    opmode_ctrl i_opmode_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .wr_en_i(wr_en_i), .wr_mode_i(wr_mode_i),
        .mode_o(mode_o), .single_o(single_o), .expanded_o(expanded_o),
        .wide_o(wide_o), .special_o(special_o), .emul_o(emul_o),
        .periph_o(periph_o), .port_a_fn_o(port_a_fn_o),
        .port_b_fn_o(port_b_fn_o), .wr_ignored_o(wr_ignored_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit allowed(input logic [2:0] cur, input logic [2:0] tgt, input bit once);
        if (cur == 3'd0 || cur == 3'd2) return 1'b1;
        if (cur == 3'd4) return !once && (tgt == 3'd5 || tgt == 3'd7);
        return 1'b0;
    endfunction

    function automatic string pol_tag(input logic [2:0] cur, input logic [2:0] tgt);
        if (cur == 3'd0 || cur == 3'd2) return "R6";
        if (cur == 3'd4) return (tgt == 3'd5 || tgt == 3'd7) ? "R7" : "R8";
        return "R9";
    endfunction

    task automatic check_decode(input logic [2:0] m);
        bit sc, pe, wd, nr;
        int pa, pb;
        sc = (m[1:0] == 2'b00);
        pe = (m == 3'd6);
        wd = m[1] && !pe;
        nr = m[0] && !m[1];
        check("R2 mode", int'(mode_o), int'(m));
        check("R2 single", int'(single_o), int'(sc));
        check("R2 expanded", int'(expanded_o), int'(!sc && !pe));
        check("R2 periph", int'(periph_o), int'(pe));
        check("R2 wide", int'(wide_o), int'(wd));
        check("R2 special", int'(special_o), int'(!m[2] && !m[0]));
        check("R2 emul", int'(emul_o), int'(!m[2] && m[0]));
        if (sc)      begin pa = 0; pb = 0; end
        else if (pe) begin pa = 3; pb = 3; end
        else if (nr) begin pa = 1; pb = 2; end
        else         begin pa = 2; pb = 2; end
        check(sc ? "R3 port_a" : nr ? "R4 port_a" : "R5 port_a", int'(port_a_fn_o), pa);
        check(sc ? "R3 port_b" : nr ? "R4 port_b" : "R5 port_b", int'(port_b_fn_o), pb);
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic do_write(input logic [2:0] tgt);
        bit acc;
        string tg;
        acc = allowed(m_mode, tgt, m_once);
        tg  = pol_tag(m_mode, tgt);
        wr_en_i   = 1'b1;
        wr_mode_i = tgt;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (acc) begin
            if (m_mode == 3'd4) m_once = 1'b1;
            m_mode = tgt;
        end
        check({tg, " mode"}, int'(mode_o), int'(m_mode));
        check("R10 ignored", int'(wr_ignored_o), int'(!acc));
        check_decode(m_mode);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            for (int t1 = 0; t1 < 8; t1++) begin
                for (int t2 = 0; t2 < 8; t2++) begin
                    rst_n   = 1'b0;
                    strap_i = 3'(7 - p);
                    @(negedge clk);
                    strap_i = 3'(p);
                    @(negedge clk);
                    rst_n   = 1'b1;
                    strap_i = 3'(~p);
                    m_mode  = 3'(p);
                    m_once  = 1'b0;
                    check("R1 strap", int'(mode_o), p);
                    check("R1 ignored", int'(wr_ignored_o), 0);
                    check_decode(m_mode);
                    do_write(3'(t1));
                    do_write(3'(t2));
                    @(negedge clk);
                    check("R10 pulse drop", int'(wr_ignored_o), 0);
                    check("R10 idle mode", int'(mode_o), int'(m_mode));
                end
            end
        end
        // R8: refused target from normal single chip, then one allowed write
        rst_n = 1'b0; strap_i = 3'd4;
        @(negedge clk);
        rst_n = 1'b1; m_mode = 3'd4; m_once = 1'b0;
        do_write(3'd6);
        do_write(3'd0);
        do_write(3'd7);
        do_write(3'd5);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule